// File: doc/BRIEF.md
# Multi-Stage Trigger Sequencer

This block decides when a capture engine should fire. A condition evaluator upstream gives it one match line per trigger stage. The sequencer walks through the stages in strict order. It watches only the match line of the stage it is in, and it moves on when that line is high. When the last active stage matches, it emits a single-cycle trigger pulse. The number of active stages is chosen at run time, between one and a synthesis-time maximum.

Each stage has its own limit, counted in clock cycles. If the stage's condition does not occur within that many cycles, the sequencer stops in a failed state. It reports which stage failed and issues no trigger. A limit of zero disables the timeout for that stage. An immediate mode fires the trigger on the cycle after arming without looking at any stage. An upstream evaluator with no condition enabled drives every match line high, so the trigger then follows after one cycle per active stage. An abort input returns the sequencer to idle from any state.

Top module: `trgseq_top`

## Requirements
- R1: After a synchronous reset, trig_o, busy_o and fail_o are 0 and stage_o is 0.
- R2: The active stage count is sampled when arming is accepted. A request of 0 is treated as 1 and a request above the maximum M is treated as M. Later changes to the request have no effect until the next arm.
- R3: While the sequencer is in stage k (stage_o = k, counted from 0), only bit k of the match vector is observed. High bits for other stages leave stage_o unchanged.
- R4: The sequencer advances at most one stage per clock. With every match bit held high and N active stages, stage_o steps 0,1,...,N-1 on successive cycles, and trig_o rises N clock edges after the arming edge.
- R5: When the last active stage's match bit is sampled high, trig_o is 1 for exactly the next cycle. At the same time busy_o falls and stage_o returns to 0.
- R6: If arm is sampled with the immediate flag high, trig_o is 1 on the next cycle and busy_o never rises.
- R7: Each stage has a limit T taken from bits [k*TW +: TW] of the timeout vector. If T is nonzero and the stage's match is not seen within T cycles (the entry cycle counts as the first), fail_o rises and stays high. stage_o then holds the failing stage, busy_o is 0 and no trigger is issued.
- R8: A match in the T-th cycle of a stage is accepted, and no failure is reported.
- R9: A limit of zero means the stage waits without end.
- R10: Abort, sampled high in any state, puts the sequencer in idle on the next cycle: busy_o, fail_o and trig_o are 0 and stage_o is 0. Abort takes priority over arm and match.
- R11: Arm is ignored while busy. Arm from the failed state clears the failure and starts a new sequence.
- R12: busy_o is 1 exactly while the sequencer is stepping through stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start a sequence (from idle or failed) |
| abort_i | input | 1 | Return to idle |
| immediate_i | input | 1 | Trigger on arm without evaluating stages |
| stage_count_i | input | SW | Requested number of active stages |
| match_i | input | M | Per-stage match lines, bit k for stage k |
| timeout_i | input | M*TW | Per-stage cycle limits, stage k at [k*TW +: TW] |
| trig_o | output | 1 | Single-cycle trigger pulse |
| stage_o | output | SW | Current stage, or the failing stage |
| fail_o | output | 1 | A stage limit expired |
| busy_o | output | 1 | Sequence in progress |

## Verification
The hardest condition to reach is the exact boundary of a stage limit. The match must land in the last permitted cycle, which is one cycle before expiry. The stimulus arms the sequencer and counts negative edges from the entry cycle. It raises the match on the T-th cycle in one run and withholds it in another, so that acceptance and failure are both seen at the same count. Strict ordering is checked by raising the match bits of later stages first and holding them for several cycles. Both checks are made while the current stage's bit is low.

// File: rtl/trgseq_pkg.sv
package trgseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FAIL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic arm;
        logic abort;
        logic immediate;
    } seq_cmd_t;

    // Bring a requested stage count into the legal range 1..maxs
    function automatic int unsigned clamp_stages(int unsigned req, int unsigned maxs);
        if (req == 0)
            return 1;
        else if (req > maxs)
            return maxs;
        else
            return req;
    endfunction

endpackage

// File: rtl/trgseq_stage_sel.sv
module trgseq_stage_sel #(
    parameter int M  = 4,
    parameter int TW = 16,
    parameter int SW = 3
) (
    input  logic [SW-1:0]   stage_idx,
    input  logic [M-1:0]    match_vec,
    input  logic [M*TW-1:0] limit_flat,
    output logic            cur_match,
    output logic [TW-1:0]   cur_limit
);

    logic [TW-1:0] limit_arr [M];

    for (genvar g = 0; g < M; g++) begin : g_unpack
        assign limit_arr[g] = limit_flat[g*TW +: TW];
    end

    always_comb begin
        cur_match = 1'b0;
        cur_limit = '0;
        for (int g = 0; g < M; g++) begin
            if (stage_idx == SW'(g)) begin
                cur_match = match_vec[g];
                cur_limit = limit_arr[g];
            end
        end
    end

endmodule

// File: rtl/trgseq_stage_timer.sv
module trgseq_stage_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + TW'(1);
    end

    // cnt_q counts completed cycles in the stage; the T-th cycle is the last one
    assign expire = (limit != '0) && (cnt_q == limit - TW'(1));

endmodule

// File: rtl/trgseq_fsm.sv
module trgseq_fsm
    import trgseq_pkg::*;
#(
    parameter int M  = 4,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_cmd_t      cmd,
    input  logic [SW-1:0] count_req,
    input  logic          cur_match,
    input  logic          cur_expire,
    output seq_state_e    state_q,
    output logic [SW-1:0] stage_q,
    output logic          trig_q,
    output logic          restart
);

    logic [SW-1:0] eff_cnt;
    logic [SW-1:0] last_q, last_n, stage_n;
    seq_state_e    state_n;
    logic          trig_n;

    assign eff_cnt = SW'(clamp_stages(32'(count_req), M));

    always_comb begin
        state_n = state_q;
        stage_n = stage_q;
        last_n  = last_q;
        trig_n  = 1'b0;
        case (state_q)
            SQ_IDLE, SQ_FAIL: begin
                if (cmd.abort) begin
                    state_n = SQ_IDLE;
                    stage_n = '0;
                end else if (cmd.arm) begin
                    stage_n = '0;
                    last_n  = eff_cnt - SW'(1);
                    if (cmd.immediate) begin
                        trig_n  = 1'b1;
                        state_n = SQ_IDLE;
                    end else begin
                        state_n = SQ_RUN;
                    end
                end
            end
            SQ_RUN: begin
                if (cmd.abort) begin
                    state_n = SQ_IDLE;
                    stage_n = '0;
                end else if (cur_match) begin
                    if (stage_q == last_q) begin
                        trig_n  = 1'b1;
                        state_n = SQ_IDLE;
                        stage_n = '0;
                    end else begin
                        stage_n = stage_q + SW'(1);
                    end
                end else if (cur_expire) begin
                    state_n = SQ_FAIL;
                end
            end
            default: begin
                state_n = SQ_IDLE;
                stage_n = '0;
            end
        endcase
    end

    assign restart = (state_q != SQ_RUN) || cur_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            stage_q <= '0;
            last_q  <= '0;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            stage_q <= stage_n;
            last_q  <= last_n;
            trig_q  <= trig_n;
        end
    end

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN) && ($past(state_q) == SQ_RUN) |->
            (stage_q == $past(stage_q)) || (stage_q == $past(stage_q) + SW'(1)));

    // R2
    stage_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN) |-> (stage_q <= last_q) && (last_q < SW'(M)));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.abort |=> (state_q == SQ_IDLE) && !trig_q && (stage_q == '0));

    // R5
    trig_source_chk: assert property (@(posedge clk) disable iff (rst)
        trig_q |-> (($past(state_q) == SQ_RUN) && $past(cur_match)) ||
                   ($past(cmd.arm) && $past(cmd.immediate)));

    // R7
    fail_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == SQ_FAIL) |-> $past(cur_expire) && !$past(cur_match) && !trig_q);

    // R11
    arm_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN) && cmd.arm && !cmd.abort && !cur_match |=>
            (stage_q == $past(stage_q)));

endmodule

// File: rtl/trgseq_top.sv
module trgseq_top
    import trgseq_pkg::*;
#(
    parameter int M  = 4,
    parameter int TW = 16,
    parameter int SW = $clog2(M + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          abort_i,
    input  logic          immediate_i,
    input  logic [SW-1:0] stage_count_i,
    input  logic [M-1:0]  match_i,
    input  logic [M*TW-1:0] timeout_i,
    output logic          trig_o,
    output logic [SW-1:0] stage_o,
    output logic          fail_o,
    output logic          busy_o
);

    seq_cmd_t      cmd;
    seq_state_e    state;
    logic [SW-1:0] stage;
    logic          cur_match, cur_expire, restart;
    logic [TW-1:0] cur_limit;

    assign cmd = '{arm: arm_i, abort: abort_i, immediate: immediate_i};

    trgseq_stage_sel #(.M(M), .TW(TW), .SW(SW)) u_sel (
        .stage_idx (stage),
        .match_vec (match_i),
        .limit_flat(timeout_i),
        .cur_match (cur_match),
        .cur_limit (cur_limit)
    );

    trgseq_stage_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .limit  (cur_limit),
        .expire (cur_expire)
    );

    trgseq_fsm #(.M(M), .SW(SW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .count_req (stage_count_i),
        .cur_match (cur_match),
        .cur_expire(cur_expire),
        .state_q   (state),
        .stage_q   (stage),
        .trig_q    (trig_o),
        .restart   (restart)
    );

    assign stage_o = stage;
    assign fail_o  = (state == SQ_FAIL);
    assign busy_o  = (state == SQ_RUN);

    // R12
    busy_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> !busy_o && !fail_o);

endmodule

// File: tb/sim_trgseq_top.sv
module sim_trgseq_top;

    localparam int M  = 4;
    localparam int TW = 16;
    localparam int SW = $clog2(M + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm_i = 1'b0, abort_i = 1'b0, immediate_i = 1'b0;
    logic [SW-1:0] stage_count_i = '0;
    logic [M-1:0]  match_i = '0;
    logic [M*TW-1:0] timeout_i = '0;
    logic          trig_o, fail_o, busy_o;
    logic [SW-1:0] stage_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    trgseq_top #(.M(M), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .arm_i(arm_i), .abort_i(abort_i),
        .immediate_i(immediate_i), .stage_count_i(stage_count_i),
        .match_i(match_i), .timeout_i(timeout_i),
        .trig_o(trig_o), .stage_o(stage_o), .fail_o(fail_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic arm_pulse();
        arm_i = 1'b1;
        tick();
        arm_i = 1'b0;
    endtask

    task automatic set_limit(input int k, input int val);
        timeout_i[k*TW +: TW] = TW'(val);
    endtask

    task automatic go_idle();
        abort_i = 1'b1;
        tick();
        abort_i = 1'b0;
        match_i = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        chk("R1", "trig", int'(trig_o), 0);
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "fail", int'(fail_o), 0);
        chk("R1", "stage", int'(stage_o), 0);
    endtask

    task automatic t_immediate();
        stage_count_i = 3;
        immediate_i = 1'b1;
        arm_pulse();
        immediate_i = 1'b0;
        chk("R6", "trig after immediate arm", int'(trig_o), 1);
        chk("R6", "busy during immediate", int'(busy_o), 0);
        tick();
        chk("R6", "trig one cycle only", int'(trig_o), 0);
    endtask

    task automatic t_order();
        timeout_i = '0;
        stage_count_i = 3;
        arm_pulse();
        chk("R12", "busy after arm", int'(busy_o), 1);
        chk("R3", "entry stage", int'(stage_o), 0);
        match_i = 4'b0110;
        repeat (3) tick();
        chk("R3", "stage 0 ignores later bits", int'(stage_o), 0);
        match_i = 4'b0001;
        tick();
        match_i = 4'b1100;
        chk("R3", "advance to stage 1", int'(stage_o), 1);
        repeat (2) tick();
        chk("R3", "stage 1 ignores later bits", int'(stage_o), 1);
        match_i = 4'b0010;
        tick();
        match_i = 4'b0000;
        chk("R3", "advance to stage 2", int'(stage_o), 2);
        chk("R5", "no early trig", int'(trig_o), 0);
        match_i = 4'b0100;
        tick();
        match_i = 4'b0000;
        chk("R5", "trig on last stage", int'(trig_o), 1);
        chk("R5", "busy drops", int'(busy_o), 0);
        chk("R5", "stage back to 0", int'(stage_o), 0);
        tick();
        chk("R5", "trig single cycle", int'(trig_o), 0);
    endtask

    task automatic t_chain();
        stage_count_i = 4;
        match_i = 4'b1111;
        arm_pulse();
        chk("R4", "chain stage 0", int'(stage_o), 0);
        for (int k = 1; k < 4; k++) begin
            tick();
            chk("R4", "chain stage step", int'(stage_o), k);
            chk("R4", "chain no trig yet", int'(trig_o), 0);
        end
        tick();
        chk("R4", "chain trig after 4 edges", int'(trig_o), 1);
        match_i = '0;
        tick();
    endtask

    task automatic t_clamp();
        match_i = 4'b1111;
        stage_count_i = 0;
        arm_pulse();
        chk("R2", "count 0 busy", int'(busy_o), 1);
        tick();
        chk("R2", "count 0 acts as 1", int'(trig_o), 1);
        stage_count_i = 7;
        arm_pulse();
        repeat (3) begin
            tick();
            chk("R2", "count 7 not done", int'(trig_o), 0);
        end
        tick();
        chk("R2", "count 7 acts as 4", int'(trig_o), 1);
        stage_count_i = 2;
        arm_pulse();
        stage_count_i = 4;
        tick();
        chk("R2", "latched count mid", int'(trig_o), 0);
        tick();
        chk("R2", "latched count 2 fires", int'(trig_o), 1);
        match_i = '0;
        tick();
    endtask

    task automatic t_timeout();
        timeout_i = '0;
        set_limit(1, 5);
        stage_count_i = 2;
        arm_pulse();
        match_i = 4'b0001;
        tick();
        match_i = 4'b0000;
        chk("R7", "in stage 1", int'(stage_o), 1);
        repeat (4) tick();
        chk("R7", "still busy in 5th cycle", int'(busy_o), 1);
        tick();
        chk("R7", "fail raised", int'(fail_o), 1);
        chk("R7", "failing stage", int'(stage_o), 1);
        chk("R7", "busy low on fail", int'(busy_o), 0);
        chk("R7", "no trig on fail", int'(trig_o), 0);
        match_i = 4'b1111;
        tick();
        chk("R7", "fail holds", int'(fail_o), 1);
        chk("R7", "no trig while failed", int'(trig_o), 0);
        match_i = '0;
        abort_i = 1'b1;
        tick();
        abort_i = 1'b0;
        chk("R10", "abort clears fail", int'(fail_o), 0);
        chk("R10", "abort stage 0", int'(stage_o), 0);
    endtask

    task automatic t_boundary();
        timeout_i = '0;
        set_limit(0, 3);
        stage_count_i = 1;
        arm_pulse();
        repeat (2) tick();
        match_i = 4'b0001;
        tick();
        match_i = '0;
        chk("R8", "match in last cycle triggers", int'(trig_o), 1);
        chk("R8", "no fail", int'(fail_o), 0);
        arm_pulse();
        repeat (3) tick();
        chk("R8", "no match by cycle 3 fails", int'(fail_o), 1);
        timeout_i = '0;
        match_i = 4'b0001;
        arm_pulse();
        chk("R11", "rearm from fail busy", int'(busy_o), 1);
        chk("R11", "rearm clears fail", int'(fail_o), 0);
        tick();
        chk("R11", "rearm run completes", int'(trig_o), 1);
        match_i = '0;
    endtask

    task automatic t_no_limit();
        timeout_i = '0;
        stage_count_i = 1;
        arm_pulse();
        repeat (300) tick();
        chk("R9", "zero limit still busy", int'(busy_o), 1);
        chk("R9", "zero limit no fail", int'(fail_o), 0);
        abort_i = 1'b1;
        arm_i = 1'b1;
        match_i = 4'b0001;
        tick();
        abort_i = 1'b0;
        arm_i = 1'b0;
        match_i = '0;
        chk("R10", "abort beats match busy", int'(busy_o), 0);
        chk("R10", "abort beats match trig", int'(trig_o), 0);
        tick();
        chk("R10", "abort stays idle", int'(busy_o), 0);
    endtask

    task automatic t_arm_busy();
        timeout_i = '0;
        stage_count_i = 3;
        arm_pulse();
        match_i = 4'b0001;
        tick();
        match_i = '0;
        arm_i = 1'b1;
        tick();
        arm_i = 1'b0;
        chk("R11", "arm ignored stage", int'(stage_o), 1);
        chk("R11", "arm ignored busy", int'(busy_o), 1);
        go_idle();
        chk("R12", "idle after abort", int'(busy_o), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_immediate();
        t_order();
        t_chain();
        t_clamp();
        t_timeout();
        t_boundary();
        t_no_limit();
        t_arm_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule